// File: doc/BRIEF.md
# RAID-5 Parity and Stripe Engine

This block is the arithmetic and sequencing core of a disk array with a rotating parity strip spread across `NUM_DRIVES` drives. It has two independent parts. A combinational address map turns a logical data strip number into its stripe number, the drive that holds it, and the drive that holds that stripe's parity. The parity position moves down by one drive from each stripe to the next, so parity lands on every drive equally often. A streaming XOR engine serves one command at a time. A command names a mode, a stripe and a drive. The engine then takes whole strips as a stream of words over a valid/ready input and returns the result strip over a valid/ready output.

Three modes share the engine. Parity generation folds the stripe's data strips together. Rebuild folds the surviving strips of a stripe to recover the strip of a known failed drive. Small-write update folds old parity, old data and new data, so the other drives are never read. For every incoming strip the engine names the drive that strip must come from. It also names the drive the result belongs to. The strips before the last are gathered in a one-strip buffer. Words of the final strip are combined with the buffer and passed straight through, so the result strip appears while that strip streams in.

Top module: `raid5_stripe_engine`

## Requirements
- R1: For a logical strip number `m`, `map_stripe` is `m div (NUM_DRIVES-1)` and `map_parity_drive` is `(NUM_DRIVES-1) - (map_stripe mod NUM_DRIVES)`.
- R2: `map_data_drive` is the drive at position `m mod (NUM_DRIVES-1)` among the drives of that stripe other than the parity drive, counted in increasing drive order. It therefore never equals the parity drive.
- R3: `cmd_mode` 2'b00 or 2'b11 generates parity. The engine takes `NUM_DRIVES-1` strips, and output word `w` is the XOR of word `w` of all of them. `out_drive` equals the parity drive of `cmd_stripe`, as defined in R1.
- R4: In parity generation, `src_drive` names the data drives in increasing order, one per strip, skipping the parity drive.
- R5: `cmd_mode` 2'b01 rebuilds the strip of drive `cmd_drive`. The engine takes `NUM_DRIVES-1` strips, and `src_drive` runs over all other drives in increasing order. The output is their word-wise XOR and `out_drive` equals `cmd_drive`.
- R6: `cmd_mode` 2'b10 updates parity for a small write to data drive `cmd_drive`. The engine takes exactly three strips, with `src_drive` equal to the parity drive, then `cmd_drive`, then `cmd_drive` (old parity, old data, new data). The output is their word-wise XOR and `out_drive` is the parity drive.
- R7: `cmd_ready` is high exactly when no command is in progress, and a command offered while busy is ignored. `done` is high for one cycle, in the cycle after the last result word is accepted, and `cmd_ready` is high again in that same cycle.
- R8: Output words appear only during the final strip, with `out_valid` equal to `in_valid` there. During that strip `in_ready` follows `out_ready`, so a stalled output holds the input word. Before the final strip `in_ready` is high whenever a command is in progress.
- R9: The buffer restarts on the first strip of every command, so a result depends only on that command's own strips.
- R10: While `rst_n` is low and after it, until a command arrives, `cmd_ready` is 1 and `in_ready`, `out_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_mode | input | 2 | 00/11 generate, 01 rebuild, 10 small-write update |
| cmd_stripe | input | STRIPE_W | Stripe number of the command |
| cmd_drive | input | DRV_W | Failed drive (rebuild) or written data drive (update) |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word taken this cycle when valid |
| in_data | input | WORD_W | Input strip word |
| src_drive | output | DRV_W | Drive the current input strip must come from |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Result word accepted |
| out_data | output | WORD_W | Result strip word |
| out_drive | output | DRV_W | Drive the result strip belongs to |
| done | output | 1 | One-cycle pulse after the last result word |
| map_strip | input | STRIP_NUM_W | Logical data strip number to map |
| map_stripe | output | STRIP_NUM_W | Stripe holding that strip |
| map_data_drive | output | DRV_W | Drive holding that strip |
| map_parity_drive | output | DRV_W | Parity drive of that stripe |

## Verification
The address map has no registers, so the bench sets `map_strip` and reads the outputs one time unit later in the same cycle. In the engine, `in_ready`, `out_valid`, `out_data` and `src_drive` respond to the current input word within the cycle. The bench drives each word on the falling edge and compares these ports against its own model just before the rising edge that would take the word. `done` and the return of `cmd_ready` come from a register, so they are due one edge after the last result word is accepted. The bench checks them on the falling edge that follows, and checks on the next one that `done` has dropped.

// File: rtl/raid5_pkg.sv
// Shared definitions for the rotating-parity stripe engine.
// Assumes stripe numbers fit in 32 bits.
package raid5_pkg;

    typedef enum logic [1:0] {
        MODE_GEN     = 2'b00,
        MODE_REBUILD = 2'b01,
        MODE_RMW     = 2'b10,
        MODE_GEN_ALT = 2'b11
    } raid_mode_e;

    // Drive carrying parity for a stripe: walks down one drive per stripe.
    function automatic int unsigned parity_home(input int unsigned stripe,
                                                input int unsigned drives);
        return (drives - 1) - (stripe % drives);
    endfunction

endpackage

// File: rtl/raid5_strip_map.sv
// Combinational logical-strip to drive map.
// Assumes NUM_DRIVES >= 3 and STRIP_NUM_W <= 32.
module raid5_strip_map
    import raid5_pkg::*;
#(
    parameter int unsigned NUM_DRIVES  = 5,
    parameter int unsigned STRIP_NUM_W = 16,
    parameter int unsigned DRV_W       = 3
) (
    input  logic [STRIP_NUM_W-1:0] strip,
    output logic [STRIP_NUM_W-1:0] stripe,
    output logic [DRV_W-1:0]       data_drive,
    output logic [DRV_W-1:0]       parity_drive
);
    localparam int unsigned DATA_PER_STRIPE = NUM_DRIVES - 1;

    int unsigned stripe_n;
    int unsigned slot_n;
    int unsigned par_n;

    // Split the strip number, then step the data slot past the parity drive.
    always_comb begin
        stripe_n     = 32'(strip) / DATA_PER_STRIPE;
        slot_n       = 32'(strip) % DATA_PER_STRIPE;
        par_n        = parity_home(stripe_n, NUM_DRIVES);
        stripe       = STRIP_NUM_W'(stripe_n);
        parity_drive = DRV_W'(par_n);
        data_drive   = (slot_n < par_n) ? DRV_W'(slot_n) : DRV_W'(slot_n + 1);
    end

endmodule

// File: rtl/raid5_xor_acc.sv
// One-strip XOR buffer. On the first strip of a command a word is loaded;
// on later strips the word is folded in. The stored word at idx is always
// visible on acc_word. Assumes idx < STRIP_WORDS.
module raid5_xor_acc #(
    parameter int unsigned WORD_W      = 32,
    parameter int unsigned STRIP_WORDS = 8,
    parameter int unsigned WIDX_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              load,
    input  logic [WIDX_W-1:0] idx,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] acc_word
);
    logic [STRIP_WORDS-1:0][WORD_W-1:0] slot_q;

    // Load or fold the addressed word; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < int'(STRIP_WORDS); i++) begin
                if (idx == WIDX_W'(i)) begin
                    slot_q[i] <= load ? din : (slot_q[i] ^ din);
                end
            end
        end
    end

    // Present the buffered word for the current word position.
    always_comb acc_word = slot_q[idx];

endmodule

// File: rtl/raid5_seq.sv
// Command sequencer: accepts one command, counts words and strips, names
// the source drive of each strip, and runs the input/output handshake.
// Assumes NUM_DRIVES in 3..8 and cmd_drive < NUM_DRIVES.
module raid5_seq
    import raid5_pkg::*;
#(
    parameter int unsigned NUM_DRIVES  = 5,
    parameter int unsigned STRIP_WORDS = 8,
    parameter int unsigned STRIPE_W    = 16,
    parameter int unsigned DRV_W       = 3,
    parameter int unsigned WIDX_W      = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [1:0]          cmd_mode,
    input  logic [STRIPE_W-1:0] cmd_stripe,
    input  logic [DRV_W-1:0]    cmd_drive,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic                out_ready,
    output logic                out_valid,
    output logic                acc_wr,
    output logic                acc_load,
    output logic [WIDX_W-1:0]   word_idx,
    output logic [DRV_W-1:0]    src_drive,
    output logic [DRV_W-1:0]    out_drive,
    output logic                done
);
    localparam logic [2:0]        GEN_LAST  = 3'(NUM_DRIVES - 2);
    localparam logic [2:0]        RMW_LAST  = 3'd2;
    localparam logic [WIDX_W-1:0] WORD_LAST = WIDX_W'(STRIP_WORDS - 1);

    logic              busy_q, done_q, rmw_q;
    logic [DRV_W-1:0]  excl_q, tgt_q, src_q;
    logic [2:0]        strip_q;
    logic [WIDX_W-1:0] word_q;

    logic              is_rmw, is_reb, accept, fire, word_end, last_strip;
    logic [DRV_W-1:0]  par_new, excl_new, tgt_new, src_new, src_next, step;

    // Decode an offered command into exclusion, target and first source.
    always_comb begin
        is_rmw   = (cmd_mode == MODE_RMW);
        is_reb   = (cmd_mode == MODE_REBUILD);
        par_new  = DRV_W'(parity_home(32'(cmd_stripe), NUM_DRIVES));
        excl_new = (is_rmw || is_reb) ? cmd_drive : par_new;
        tgt_new  = is_reb ? cmd_drive : par_new;
        if (is_rmw)
            src_new = par_new;
        else
            src_new = (excl_new == '0) ? DRV_W'(1) : '0;
    end

    // Next source drive: skip the excluded drive, or hold the data drive.
    always_comb begin
        step = src_q + 1'b1;
        if (step == excl_q)
            step = step + 1'b1;
        src_next = rmw_q ? excl_q : step;
    end

    // Handshake and position flags.
    always_comb begin
        cmd_ready  = !busy_q;
        accept     = cmd_valid && !busy_q;
        last_strip = (strip_q == (rmw_q ? RMW_LAST : GEN_LAST));
        word_end   = (word_q == WORD_LAST);
        in_ready   = busy_q && (!last_strip || out_ready);
        out_valid  = busy_q && last_strip && in_valid;
        fire       = in_valid && in_ready;
        acc_wr     = fire && !last_strip;
        acc_load   = (strip_q == 3'd0);
        word_idx   = word_q;
        src_drive  = src_q;
        out_drive  = tgt_q;
        done       = done_q;
    end

    // Command capture, word and strip counting, completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            rmw_q   <= 1'b0;
            excl_q  <= '0;
            tgt_q   <= '0;
            src_q   <= '0;
            strip_q <= '0;
            word_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q  <= 1'b1;
                rmw_q   <= is_rmw;
                excl_q  <= excl_new;
                tgt_q   <= tgt_new;
                src_q   <= src_new;
                strip_q <= '0;
                word_q  <= '0;
            end else if (fire) begin
                if (word_end) begin
                    word_q <= '0;
                    if (last_strip) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        strip_q <= strip_q + 3'd1;
                        src_q   <= src_next;
                    end
                end else begin
                    word_q <= word_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/raid5_stripe_engine.sv
// Top of the rotating-parity stripe engine: the strip address map plus a
// streaming XOR engine for parity generation, rebuild and small-write
// update. Result words leave combinationally while the final strip enters.
// Assumes NUM_DRIVES in 3..8 and STRIP_WORDS >= 2.
module raid5_stripe_engine
    import raid5_pkg::*;
#(
    parameter  int unsigned NUM_DRIVES  = 5,
    parameter  int unsigned WORD_W      = 32,
    parameter  int unsigned STRIP_WORDS = 8,
    parameter  int unsigned STRIPE_W    = 16,
    parameter  int unsigned STRIP_NUM_W = 16,
    localparam int unsigned DRV_W       = $clog2(NUM_DRIVES),
    localparam int unsigned WIDX_W      = $clog2(STRIP_WORDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic [1:0]             cmd_mode,
    input  logic [STRIPE_W-1:0]    cmd_stripe,
    input  logic [DRV_W-1:0]       cmd_drive,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [WORD_W-1:0]      in_data,
    output logic [DRV_W-1:0]       src_drive,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [WORD_W-1:0]      out_data,
    output logic [DRV_W-1:0]       out_drive,
    output logic                   done,
    input  logic [STRIP_NUM_W-1:0] map_strip,
    output logic [STRIP_NUM_W-1:0] map_stripe,
    output logic [DRV_W-1:0]       map_data_drive,
    output logic [DRV_W-1:0]       map_parity_drive
);
    logic              acc_wr, acc_load;
    logic [WIDX_W-1:0] word_idx;
    logic [WORD_W-1:0] acc_word;

    raid5_strip_map #(
        .NUM_DRIVES (NUM_DRIVES),
        .STRIP_NUM_W(STRIP_NUM_W),
        .DRV_W      (DRV_W)
    ) u_map (
        .strip       (map_strip),
        .stripe      (map_stripe),
        .data_drive  (map_data_drive),
        .parity_drive(map_parity_drive)
    );

    raid5_seq #(
        .NUM_DRIVES (NUM_DRIVES),
        .STRIP_WORDS(STRIP_WORDS),
        .STRIPE_W   (STRIPE_W),
        .DRV_W      (DRV_W),
        .WIDX_W     (WIDX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_mode  (cmd_mode),
        .cmd_stripe(cmd_stripe),
        .cmd_drive (cmd_drive),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .acc_wr    (acc_wr),
        .acc_load  (acc_load),
        .word_idx  (word_idx),
        .src_drive (src_drive),
        .out_drive (out_drive),
        .done      (done)
    );

    raid5_xor_acc #(
        .WORD_W     (WORD_W),
        .STRIP_WORDS(STRIP_WORDS),
        .WIDX_W     (WIDX_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc_wr),
        .load    (acc_load),
        .idx     (word_idx),
        .din     (in_data),
        .acc_word(acc_word)
    );

    // Final strip word folded with the buffered partial result.
    always_comb out_data = acc_word ^ in_data;

endmodule

// File: rtl/raid5_engine_chk.sv
// Property checker for the stripe engine, attached by bind. It records the
// accepted command so that the drive-selection rules can be checked.
module raid5_engine_chk #(
    parameter int unsigned NUM_DRIVES  = 5,
    parameter int unsigned STRIPE_W    = 16,
    parameter int unsigned STRIP_NUM_W = 16,
    parameter int unsigned DRV_W       = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_valid,
    input logic                   cmd_ready,
    input logic [1:0]             cmd_mode,
    input logic [DRV_W-1:0]       cmd_drive,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic [DRV_W-1:0]       src_drive,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [DRV_W-1:0]       out_drive,
    input logic                   done,
    input logic [DRV_W-1:0]       map_data_drive,
    input logic [DRV_W-1:0]       map_parity_drive
);
    localparam logic [DRV_W-1:0] TOP_DRV = DRV_W'(NUM_DRIVES - 1);

    logic [1:0]       rec_mode;
    logic [DRV_W-1:0] rec_drive;

    // Remember the mode and drive of the command in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_mode  <= 2'b00;
            rec_drive <= '0;
        end else if (cmd_valid && cmd_ready) begin
            rec_mode  <= cmd_mode;
            rec_drive <= cmd_drive;
        end
    end

    p_map_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        map_parity_drive <= TOP_DRV);

    p_map_skip_parity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (map_data_drive != map_parity_drive) && (map_data_drive <= TOP_DRV));

    p_target_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && !$past(cmd_ready)) |-> $stable(out_drive));

    p_gen_skips_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && (rec_mode == 2'b00 || rec_mode == 2'b11))
            |-> (src_drive != out_drive && src_drive <= TOP_DRV));

    p_rebuild_skips_failed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && rec_mode == 2'b01)
            |-> (src_drive != rec_drive && out_drive == rec_drive));

    p_rmw_target_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && rec_mode == 2'b10) |-> (out_drive != rec_drive));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!in_ready && !out_valid));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd_ready && !$past(cmd_ready)));

    p_out_needs_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_valid);

    p_stall_holds_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

bind raid5_stripe_engine raid5_engine_chk #(
    .NUM_DRIVES (NUM_DRIVES),
    .STRIPE_W   (STRIPE_W),
    .STRIP_NUM_W(STRIP_NUM_W),
    .DRV_W      (DRV_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_valid       (cmd_valid),
    .cmd_ready       (cmd_ready),
    .cmd_mode        (cmd_mode),
    .cmd_drive       (cmd_drive),
    .in_valid        (in_valid),
    .in_ready        (in_ready),
    .src_drive       (src_drive),
    .out_valid       (out_valid),
    .out_ready       (out_ready),
    .out_drive       (out_drive),
    .done            (done),
    .map_data_drive  (map_data_drive),
    .map_parity_drive(map_parity_drive)
);

// File: tb/raid5_stripe_engine_test.sv
module raid5_stripe_engine_test;
    localparam int N   = 5;
    localparam int WW  = 32;
    localparam int SW  = 8;
    localparam int SNW = 16;
    localparam int DW  = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_mode = 2'b00;
    logic [15:0]   cmd_stripe = '0;
    logic [DW-1:0] cmd_drive = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [WW-1:0] in_data = '0;
    logic [DW-1:0] src_drive;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [WW-1:0] out_data;
    logic [DW-1:0] out_drive;
    logic          done;
    logic [SNW-1:0] map_strip = '0;
    logic [SNW-1:0] map_stripe;
    logic [DW-1:0]  map_data_drive;
    logic [DW-1:0]  map_parity_drive;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    raid5_stripe_engine #(
        .NUM_DRIVES(N), .WORD_W(WW), .STRIP_WORDS(SW),
        .STRIPE_W(16), .STRIP_NUM_W(SNW)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mode(cmd_mode),
        .cmd_stripe(cmd_stripe), .cmd_drive(cmd_drive),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .src_drive(src_drive),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_drive(out_drive), .done(done),
        .map_strip(map_strip), .map_stripe(map_stripe),
        .map_data_drive(map_data_drive), .map_parity_drive(map_parity_drive)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run is a failed check and still reaches the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected at most 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Parity drive of a stripe per R1.
    function automatic int ref_parity(input int stripe);
        return (N - 1) - (stripe % N);
    endfunction

    // Mapper check against an enumerating model (R1, R2).
    task automatic map_check(input int m);
        int st, pos, par, cnt, dd;
        st  = m / (N - 1);
        pos = m % (N - 1);
        par = ref_parity(st);
        cnt = 0;
        dd  = -1;
        for (int d = 0; d < N; d++) begin
            if (d != par) begin
                if (cnt == pos) dd = d;
                cnt++;
            end
        end
        map_strip = SNW'(m);
        #1;
        chk(map_stripe == SNW'(st), "R1 stripe", 64'(map_stripe), 64'(st));
        chk(map_parity_drive == DW'(par), "R1 parity drive", 64'(map_parity_drive), 64'(par));
        chk(map_data_drive == DW'(dd), "R2 data drive", 64'(map_data_drive), 64'(dd));
    endtask

    // One command: modes 0/3 generate, 1 rebuild, 2 small-write update.
    task automatic run_cmd(input int mode, input int stripe, input int drv,
                           input bit stall, input bit bubbles, input string rtag);
        logic [WW-1:0] sd [8][SW];
        logic [WW-1:0] expw [SW];
        int srcs [8];
        int nstr, par, tgt, excl, k;
        string res_tag, src_tag;
        bit last, acc, bub;

        par = ref_parity(stripe);
        if (mode == 2) begin
            nstr = 3; srcs[0] = par; srcs[1] = drv; srcs[2] = drv; tgt = par;
            res_tag = "R6 result"; src_tag = "R6 source";
        end else begin
            excl = (mode == 1) ? drv : par;
            tgt  = excl;
            nstr = N - 1;
            k = 0;
            for (int d = 0; d < N; d++) if (d != excl) begin srcs[k] = d; k++; end
            res_tag = (mode == 1) ? "R5 result" : "R3 result";
            src_tag = (mode == 1) ? "R5 source" : "R4 source";
        end
        if (rtag != "") res_tag = rtag;
        for (int w = 0; w < SW; w++) begin
            expw[w] = '0;
            for (int s = 0; s < nstr; s++) begin
                sd[s][w] = $urandom();
                expw[w]  = expw[w] ^ sd[s][w];
            end
        end

        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_mode   = 2'(mode);
        cmd_stripe = 16'(stripe);
        cmd_drive  = DW'(drv);
        #1;
        chk(cmd_ready == 1'b1, "R7 ready idle", 64'(cmd_ready), 64'd1);
        @(posedge clk);

        for (int s = 0; s < nstr; s++) begin
            for (int w = 0; w < SW; w++) begin
                acc = 1'b0;
                while (!acc) begin
                    @(negedge clk);
                    // Offer a conflicting command while busy when bubbles on (R7).
                    cmd_valid = bubbles;
                    cmd_mode  = 2'(mode ^ 1);
                    last = (s == nstr - 1);
                    bub  = bubbles && (($urandom() % 4) == 0);
                    if (bub) begin
                        in_valid  = 1'b0;
                        out_ready = 1'b1;
                        #1;
                        chk(out_valid == 1'b0, "R8 no word", 64'(out_valid), 64'd0);
                        chk(cmd_ready == 1'b0, "R7 busy", 64'(cmd_ready), 64'd0);
                    end else begin
                        in_valid  = 1'b1;
                        in_data   = sd[s][w];
                        out_ready = (last && stall) ? 1'($urandom() % 2) : 1'b1;
                        #1;
                        chk(src_drive == DW'(srcs[s]), src_tag, 64'(src_drive), 64'(srcs[s]));
                        chk(in_ready == (last ? out_ready : 1'b1), "R8 in_ready",
                            64'(in_ready), 64'(last ? out_ready : 1'b1));
                        chk(out_valid == last, "R8 out_valid", 64'(out_valid), 64'(last));
                        chk(cmd_ready == 1'b0, "R7 busy", 64'(cmd_ready), 64'd0);
                        if (last) begin
                            chk(out_data == expw[w], res_tag, 64'(out_data), 64'(expw[w]));
                            chk(out_drive == DW'(tgt), "R3 R5 R6 target", 64'(out_drive), 64'(tgt));
                        end
                        acc = last ? out_ready : 1'b1;
                    end
                    @(posedge clk);
                end
            end
        end

        @(negedge clk);
        in_valid  = 1'b0;
        cmd_valid = 1'b0;
        out_ready = 1'b1;
        #1;
        chk(done == 1'b1, "R7 done pulse", 64'(done), 64'd1);
        chk(cmd_ready == 1'b1, "R7 ready again", 64'(cmd_ready), 64'd1);
        @(negedge clk);
        #1;
        chk(done == 1'b0, "R7 done single", 64'(done), 64'd0);
    endtask

    initial begin
        // R10: reset state, with input offered.
        in_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(cmd_ready == 1'b1, "R10 cmd_ready", 64'(cmd_ready), 64'd1);
        chk(in_ready == 1'b0, "R10 in_ready", 64'(in_ready), 64'd0);
        chk(out_valid == 1'b0, "R10 out_valid", 64'(out_valid), 64'd0);
        chk(done == 1'b0, "R10 done", 64'(done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(in_ready == 1'b0, "R10 idle after reset", 64'(in_ready), 64'd0);
        in_valid = 1'b0;

        // R1, R2: address map over several full rotations.
        for (int m = 0; m < 3 * N * (N - 1); m++) map_check(m);
        map_check(65535);

        // R3, R4: parity generation with parity at the top, middle and bottom.
        run_cmd(0, 0, 0, 1'b0, 1'b0, "");
        run_cmd(0, 3, 0, 1'b0, 1'b0, "");
        run_cmd(0, 4, 0, 1'b0, 1'b0, "");
        run_cmd(3, 7, 0, 1'b1, 1'b1, "");
        // R5: rebuild of the first, a middle and the last drive.
        run_cmd(1, 2, 0, 1'b0, 1'b0, "");
        run_cmd(1, 9, 2, 1'b0, 1'b1, "");
        run_cmd(1, 1, 4, 1'b1, 1'b0, "");
        // R6: small-write updates.
        run_cmd(2, 2, 0, 1'b0, 1'b0, "");
        run_cmd(2, 5, 3, 1'b1, 1'b1, "");
        // R9: back-to-back commands on the same stripe, fresh data.
        run_cmd(0, 6, 0, 1'b0, 1'b0, "R9 restart");
        run_cmd(2, 6, 1, 1'b0, 1'b0, "R9 restart");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule